// File: doc/BRIEF.md
# Address Canonical-Form Scanner

This block scans a fixed, indexed set of 64-bit address fields before a change of execution mode and decides whether every checked field is in canonical form. A field is canonical when all bits above the top implemented linear-address bit are copies of that bit. The implemented width is 48 or 57 bits. Fields are read one per clock from an external register array. The block presents the field index on `rd_idx` and samples `rd_data` in the same cycle. A level-sensitive start/done handshake frames each scan. When the scan ends, `pass` gives the verdict and `fail_idx` names the first field that failed.

Most fields are judged at the width the processor supports. Three index positions follow special rules. The instruction-pointer slot is judged at the width of the target paging depth, and only when the transition enters 64-bit mode. The local-descriptor-table base slot is checked only when that table is marked usable. The bounds-configuration slot is checked only when its load flag is set. All rule inputs are captured when the scan starts.

A separate combinational load path turns a raw saved value into a canonical register value. It keeps the low implemented bits and replicates the top implemented bit into every bit above it.

Top module: `canon_scan_top`

## Requirements
- R1: With `cap_5lvl`=0, a general field passes only when bits 63:47 are all equal. Values such as 0x0000_8000_0000_0000 fail.
- R2: With `cap_5lvl`=1, a general field passes only when bits 63:56 are all equal, whatever the target paging depth. 0x0000_8000_0000_0000 then passes and 0x0100_0000_0000_0000 fails.
- R3: Field index 15 (instruction pointer) is judged on bits 63:47 when `tgt_5lvl`=0 and on bits 63:56 when `tgt_5lvl`=1. It is not checked at all when `tgt_64bit`=0.
- R4: Field index 12 (descriptor-table base) is checked only when `ldt_usable`=1. Otherwise any value there passes.
- R5: Field index 13 (bounds configuration) is checked only when `bnd_load`=1. Otherwise any value there passes.
- R6: Fields 0 to `scan_len`-1 are read in ascending order, one per clock. The first failing field ends the scan and its index appears on `fail_idx`. A scan that fails at index f raises `done` f+2 clocks after `start` is first seen, and a passing scan of L fields raises it after L+1 clocks. Fields at or beyond `scan_len` are never checked.
- R7: `done` stays high, together with a stable result, for as long as `start` stays high. One clock after `start` falls, `done` is low.
- R8: A `scan_len` of 0 gives `done` with `pass`=1 one clock after `start`.
- R9: Dropping and raising `start` again while a scan is running does not restart, stop or alter the scan.
- R10: `ld_out` equals `ld_raw` bits 47:0 with bit 47 copied into bits 63:48 when `cap_5lvl`=0. It equals bits 56:0 with bit 56 copied into bits 63:57 when `cap_5lvl`=1.
- R11: During and right after reset, `busy`, `done`, `pass` and `rd_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan request, level-held until done is seen |
| scan_len | input | 5 | Number of fields to scan (0 to 16) |
| cap_5lvl | input | 1 | Processor supports 57-bit linear addresses |
| tgt_5lvl | input | 1 | Transition results in 5-level paging |
| tgt_64bit | input | 1 | Transition enters 64-bit mode |
| ldt_usable | input | 1 | Descriptor-table base field is in use |
| bnd_load | input | 1 | Bounds-configuration field will be loaded |
| rd_idx | output | 4 | Index of the field being read |
| rd_data | input | 64 | Value of the field at rd_idx |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, result valid |
| pass | output | 1 | All checked fields canonical |
| fail_idx | output | 4 | Index of the first failing field |
| ld_raw | input | 64 | Raw value for the load path |
| ld_out | output | 64 | Sign-extended canonical value |

## Verification
The hardest condition to create from the ports is a restart request that arrives in the middle of a running scan. To the block it looks like a fresh start, yet it must change nothing. The bench drops `start` two clocks into a scan that will fail deep in the array, raises it again on the next clock, and then checks that the failing index and the completion clock are the same as for an undisturbed scan. It also places two faults in one array, so that only the earlier one may be reported. It plants malformed values in the conditional slots with their enable flags off, which shows that those slots are skipped rather than merely lucky.

// File: rtl/canon_pkg.sv
package canon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_st_t;

  typedef struct packed {
    logic cap5;
    logic tgt5;
    logic tgt64;
    logic ldt_ok;
    logic bnd_ld;
  } scan_cfg_t;

endpackage

// File: rtl/canon_rst_sync.sv
module canon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/canon_rule.sv
module canon_rule #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 48,
  parameter int WIDE_W   = 57
) (
  input  logic [ADDR_W-1:0] val,
  input  logic              wide,
  output logic              ok
);
  localparam int NUP = ADDR_W - NARROW_W + 1;
  localparam int WUP = ADDR_W - WIDE_W + 1;

  logic [NUP-1:0] top_n;
  logic [WUP-1:0] top_w;
  logic           ok_n;
  logic           ok_w;

  assign top_n = val[ADDR_W-1:NARROW_W-1];
  assign top_w = val[ADDR_W-1:WIDE_W-1];
  assign ok_n  = (&top_n) | ~(|top_n);
  assign ok_w  = (&top_w) | ~(|top_w);
  assign ok    = wide ? ok_w : ok_n;
endmodule

// File: rtl/canon_sext.sv
module canon_sext #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 48,
  parameter int WIDE_W   = 57
) (
  input  logic [ADDR_W-1:0] raw,
  input  logic              wide,
  output logic [ADDR_W-1:0] ext
);
  logic [ADDR_W-1:0] ext_n;
  logic [ADDR_W-1:0] ext_w;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < NARROW_W) begin : g_n_lo
      assign ext_n[b] = raw[b];
    end else begin : g_n_hi
      assign ext_n[b] = raw[NARROW_W-1];
    end
    if (b < WIDE_W) begin : g_w_lo
      assign ext_w[b] = raw[b];
    end else begin : g_w_hi
      assign ext_w[b] = raw[WIDE_W-1];
    end
  end

  assign ext = wide ? ext_w : ext_n;
endmodule

// File: rtl/canon_ctrl.sv
module canon_ctrl
  import canon_pkg::*;
#(
  parameter int NUM_FIELDS = 16,
  parameter int IDX_W      = $clog2(NUM_FIELDS),
  parameter int CNT_W      = $clog2(NUM_FIELDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] scan_len,
  input  scan_cfg_t        cfg_in,
  input  logic             fld_ok,
  output scan_cfg_t        cfg_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             busy,
  output logic             done,
  output logic             pass_q,
  output logic [IDX_W-1:0] fidx_q
);
  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(NUM_FIELDS);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  scan_st_t         st_q, st_d;
  scan_cfg_t        cfg_d;
  logic [IDX_W-1:0] idx_d, fidx_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             pass_d;
  logic             upd_en;
  logic             last_fld;

  assign last_fld = (CNT_W'(idx_q) == (len_q - ONE));

  always_comb begin
    st_d   = st_q;
    cfg_d  = cfg_q;
    idx_d  = idx_q;
    fidx_d = fidx_q;
    len_d  = len_q;
    pass_d = pass_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cfg_d  = cfg_in;
          len_d  = (scan_len > LEN_MAX) ? LEN_MAX : scan_len;
          idx_d  = '0;
          fidx_d = '0;
          if (scan_len == '0) begin
            st_d   = ST_DONE;
            pass_d = 1'b1;
          end else begin
            st_d   = ST_SCAN;
            pass_d = 1'b0;
          end
        end
      end
      ST_SCAN: begin
        if (!fld_ok) begin
          st_d   = ST_DONE;
          fidx_d = idx_q;
          pass_d = 1'b0;
        end else if (last_fld) begin
          st_d   = ST_DONE;
          pass_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DONE: begin
        if (!start) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign upd_en = start | (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      idx_q  <= '0;
      fidx_q <= '0;
      len_q  <= '0;
      pass_q <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      idx_q  <= idx_d;
      fidx_q <= fidx_d;
      len_q  <= len_d;
      pass_q <= pass_d;
    end
  end

  assign busy = (st_q == ST_SCAN);
  assign done = (st_q == ST_DONE);
endmodule

// File: rtl/canon_scan_top.sv
module canon_scan_top
  import canon_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int NARROW_W   = 48,
  parameter int WIDE_W     = 57,
  parameter int NUM_FIELDS = 16,
  parameter int LDT_IDX    = 12,
  parameter int BND_IDX    = 13,
  parameter int IP_IDX     = 15,
  parameter int IDX_W      = $clog2(NUM_FIELDS),
  parameter int CNT_W      = $clog2(NUM_FIELDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  scan_len,
  input  logic              cap_5lvl,
  input  logic              tgt_5lvl,
  input  logic              tgt_64bit,
  input  logic              ldt_usable,
  input  logic              bnd_load,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [IDX_W-1:0]  fail_idx,
  input  logic [ADDR_W-1:0] ld_raw,
  output logic [ADDR_W-1:0] ld_out
);
  localparam logic [IDX_W-1:0] LDT_SEL = IDX_W'(LDT_IDX);
  localparam logic [IDX_W-1:0] BND_SEL = IDX_W'(BND_IDX);
  localparam logic [IDX_W-1:0] IP_SEL  = IDX_W'(IP_IDX);

  logic      rst_n_int;
  scan_cfg_t cfg_in, cfg_q;
  logic      ok_cap, ok_tgt, fld_ok;

  canon_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign cfg_in = '{cap5: cap_5lvl, tgt5: tgt_5lvl, tgt64: tgt_64bit,
                    ldt_ok: ldt_usable, bnd_ld: bnd_load};

  canon_rule #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_rule_cap (
    .val  (rd_data),
    .wide (cfg_q.cap5),
    .ok   (ok_cap)
  );

  canon_rule #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_rule_tgt (
    .val  (rd_data),
    .wide (cfg_q.tgt5),
    .ok   (ok_tgt)
  );

  always_comb begin
    if (rd_idx == IP_SEL)       fld_ok = ~cfg_q.tgt64  | ok_tgt;
    else if (rd_idx == LDT_SEL) fld_ok = ~cfg_q.ldt_ok | ok_cap;
    else if (rd_idx == BND_SEL) fld_ok = ~cfg_q.bnd_ld | ok_cap;
    else                        fld_ok = ok_cap;
  end

  canon_ctrl #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start),
    .scan_len (scan_len),
    .cfg_in   (cfg_in),
    .fld_ok   (fld_ok),
    .cfg_q    (cfg_q),
    .idx_q    (rd_idx),
    .busy     (busy),
    .done     (done),
    .pass_q   (pass),
    .fidx_q   (fail_idx)
  );

  canon_sext #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_sext (
    .raw  (ld_raw),
    .wide (cap_5lvl),
    .ext  (ld_out)
  );
endmodule

// File: rtl/canon_scan_sva.sv
module canon_scan_sva #(
  parameter int ADDR_W = 64,
  parameter int WIDE_W = 57,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [IDX_W-1:0]  fail_idx,
  input logic              cap_5lvl,
  input logic [ADDR_W-1:0] ld_raw,
  input logic [ADDR_W-1:0] ld_out
);
  p_excl_busy_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_step_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

  p_first_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(busy) && !pass) |-> (fail_idx == $past(rd_idx)));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (done && $stable(pass) && $stable(fail_idx)));

  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_sext_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_5lvl |-> ((ld_out[ADDR_W-1:WIDE_W-1] == '0 || ld_out[ADDR_W-1:WIDE_W-1] == '1)
                  && ld_out[WIDE_W-1:0] == ld_raw[WIDE_W-1:0]));
endmodule

bind canon_scan_top canon_scan_sva #(.ADDR_W(ADDR_W), .WIDE_W(WIDE_W), .IDX_W(IDX_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .rd_idx   (rd_idx),
  .fail_idx (fail_idx),
  .cap_5lvl (cap_5lvl),
  .ld_raw   (ld_raw),
  .ld_out   (ld_out)
);

// File: tb/canon_scan_top_test.sv
module canon_scan_top_test;
  localparam int NF = 16;

  typedef struct packed {
    logic        cap;
    logic        t5;
    logic        t64;
    logic        ldt;
    logic        bnd;
    logic [4:0]  len;
    logic [4:0]  bad;
    logic [63:0] val;
    logic        ep;
    logic [3:0]  ef;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd16, 5'd31, 64'h0, 1'b1, 4'd0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd16, 5'd3, 64'h0000_8000_0000_0000, 1'b0, 4'd3},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd16, 5'd3, 64'h0000_8000_0000_0000, 1'b1, 4'd0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd16, 5'd5, 64'h0100_0000_0000_0000, 1'b0, 4'd5},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd16, 5'd15, 64'h0000_8000_0000_0000, 1'b0, 4'd15},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd16, 5'd15, 64'h0000_8000_0000_0000, 1'b1, 4'd0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd16, 5'd15, 64'h1234_0000_0000_0000, 1'b1, 4'd0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd16, 5'd12, 64'h1234_0000_0000_0000, 1'b1, 4'd0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd16, 5'd12, 64'h1234_0000_0000_0000, 1'b0, 4'd12},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd16, 5'd13, 64'h1234_0000_0000_0000, 1'b1, 4'd0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd16, 5'd13, 64'h1234_0000_0000_0000, 1'b0, 4'd13},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd4, 5'd7, 64'h5555_0000_0000_0000, 1'b1, 4'd0}
  };

  logic        clk, rst_n, start;
  logic [4:0]  scan_len;
  logic        cap_5lvl, tgt_5lvl, tgt_64bit, ldt_usable, bnd_load;
  logic [3:0]  rd_idx, fail_idx;
  logic [63:0] rd_data, ld_raw, ld_out;
  logic        busy, done, pass;
  logic [63:0] mem [NF];

  int checks = 0;
  int errors = 0;

  assign rd_data = mem[rd_idx];

  canon_scan_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_len(scan_len),
    .cap_5lvl(cap_5lvl), .tgt_5lvl(tgt_5lvl), .tgt_64bit(tgt_64bit),
    .ldt_usable(ldt_usable), .bnd_load(bnd_load), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy), .done(done), .pass(pass),
    .fail_idx(fail_idx), .ld_raw(ld_raw), .ld_out(ld_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < NF; i++)
      mem[i] = (i % 2 == 1) ? (64'hFFFF_FFFF_FFFF_F000 - 64'(i) * 64'h1000) : 64'(i) * 64'h1000;
  endtask

  task automatic set_cfg(input logic c, input logic t5, input logic t64,
                         input logic l, input logic b, input logic [4:0] n);
    cap_5lvl = c; tgt_5lvl = t5; tgt_64bit = t64; ldt_usable = l; bnd_load = b; scan_len = n;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    start = 1'b1;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done || cyc > 100) break;
    end
  endtask

  task automatic release_start(input string req);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req, {63'd0, done}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    int exp_cyc;
    rst_n = 1'b0;
    start = 1'b0;
    ld_raw = '0;
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd16);
    fill_mem();
    repeat (3) @(negedge clk);
    chk("R11 busy", {63'd0, busy}, 64'd0);
    chk("R11 done", {63'd0, done}, 64'd0);
    chk("R11 pass", {63'd0, pass}, 64'd0);
    chk("R11 rd_idx", {60'd0, rd_idx}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 idle after release", {62'd0, busy, done}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      fill_mem();
      if (VEC[v].bad != 5'd31) mem[VEC[v].bad[3:0]] = VEC[v].val;
      set_cfg(VEC[v].cap, VEC[v].t5, VEC[v].t64, VEC[v].ldt, VEC[v].bnd, VEC[v].len);
      wait_done(cyc);
      exp_cyc = VEC[v].ep ? int'(VEC[v].len) + 1 : int'(VEC[v].ef) + 2;
      chk($sformatf("R1/R2/R3/R4/R5 vec%0d pass", v), {63'd0, pass}, {63'd0, VEC[v].ep});
      if (!VEC[v].ep)
        chk($sformatf("R6 vec%0d fail_idx", v), {60'd0, fail_idx}, {60'd0, VEC[v].ef});
      chk($sformatf("R6 vec%0d cycles", v), 64'(cyc), 64'(exp_cyc));
      release_start("R7 done drops");
    end

    // R6: two faults, earlier one wins; R7: hold while start stays high
    fill_mem();
    mem[2] = 64'h0000_8000_0000_0000;
    mem[9] = 64'h7000_0000_0000_0000;
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd16);
    wait_done(cyc);
    chk("R6 first fault index", {60'd0, fail_idx}, 64'd2);
    chk("R6 first fault cycles", 64'(cyc), 64'd4);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 done held", {62'd0, done, pass}, 64'd2);
      chk("R7 fail_idx held", {60'd0, fail_idx}, 64'd2);
    end
    release_start("R7 release");

    // R9: restart request mid-scan is ignored
    fill_mem();
    mem[10] = 64'h0100_0000_0000_0000;
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd16);
    start = 1'b1;
    cyc = 0;
    repeat (3) begin @(posedge clk); cyc++; end
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); cyc++;
    @(negedge clk);
    start = 1'b1;
    while (!done && cyc < 100) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    chk("R9 result unchanged", {62'd0, done, pass}, 64'd2);
    chk("R9 fail_idx", {60'd0, fail_idx}, 64'd10);
    chk("R9 cycles", 64'(cyc), 64'd12);
    release_start("R9 release");

    // R8: zero-length scan passes even with a bad field 0
    fill_mem();
    mem[0] = 64'h0000_8000_0000_0000;
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd0);
    wait_done(cyc);
    chk("R8 zero length pass", {63'd0, pass}, 64'd1);
    chk("R8 zero length cycles", 64'(cyc), 64'd1);
    release_start("R8 release");

    // R10: load path
    cap_5lvl = 1'b0; ld_raw = 64'h1234_8000_0000_0001; #1;
    chk("R10 narrow neg", ld_out, 64'hFFFF_8000_0000_0001);
    ld_raw = 64'h00AB_7FFF_FFFF_FFFF; #1;
    chk("R10 narrow pos", ld_out, 64'h0000_7FFF_FFFF_FFFF);
    cap_5lvl = 1'b1; ld_raw = 64'h1234_8000_0000_0001; #1;
    chk("R10 wide pos", ld_out, 64'h0034_8000_0000_0001);
    ld_raw = 64'h0100_0000_0000_0005; #1;
    chk("R10 wide neg", ld_out, 64'hFF00_0000_0000_0005);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule